// File: doc/BRIEF.md
# Configurable Symmetric Array Logic Cell

This block is one fine-grained cell of a regular array fabric. Each of its four neighbours (north, south, east, west) hands it one A signal and one B signal. The cell picks one A signal and one B signal through two selectors that are configured separately, gates them into a left and a right product term, and then maps those terms onto a single A output and a single B output. Both outputs fan out to all four neighbours. One shared function state sets both output selectors together, so the state chooses the whole cell function: pass-through, swapped pass-through, XOR/AND, or a registered XOR held in a flip-flop on the column clock.

The cell also connects to four local bus lines: north-south 1, east-west 1, north-south 2 and east-west 2. It can read one of them into the left product term, write its A output onto any of them, and turn a signal through 90 degrees between the two lines of a pair. Tri-stated writes are shown as a data bit and an output-enable bit for each line, so the surrounding fabric or a testbench resolves the shared wire. If the configuration puts one line into more than one operation, the cell raises an error flag and leaves that line undriven.

The cell has no function until its configuration word is loaded. A write strobe stores the word in a register, and the column reset clears both that register and the function flip-flop.

Top module: `sac_cell`

## Requirements
- R1: A high `cfg_we` at a rising clock edge stores `cfg_wdata` into the configuration register. A high `col_rst` at an edge clears both the configuration register and the function flip-flop to 0. Configuration bit fields: a_sel [2:0], b_sel [5:3], state [7:6], rd_mode [9:8], rd_bus [11:10], wr_en [15:12] (one bit per bus, bus index = bit offset), drv_en [16], drv_tri [17], turn1 [18], turn1_dir [19], turn2 [20], turn2_dir [21].
- R2: The A selector outputs `a_in[a_sel]` when a_sel is 0 to 3, and constant 1 when a_sel is 4 to 7. The B selector works the same way on `b_in` with b_sel, independently of the A selector. Neighbour index: 0 north, 1 south, 2 east, 3 west.
- R3: Left term = A selector result AND read value. Right term = B selector result. The read value is `bus_in[rd_bus]` when rd_mode = 1, the function flip-flop when rd_mode = 2, and constant 1 when rd_mode is 0 or 3. Bus index: 0 NS1, 1 EW1, 2 NS2, 3 EW2.
- R4: In state 0, a_out = left and b_out = right. In state 1, a_out = right and b_out = left.
- R5: In state 2, a_out = left XOR right and b_out = left AND right.
- R6: In state 3, a_out and b_out both equal the function flip-flop. This flip-flop loads left XOR right at every rising edge of `col_clk`.
- R7: Bus i is written with a_out (bus_oe[i] = 1, bus_out[i] = a_out) when wr_en[i] and drv_en are set, bus i has no conflict, and either drv_tri = 0 or the B selector result is 1.
- R8: When turn1 is set, turn1_dir = 0 drives EW1 with the value of NS1, and turn1_dir = 1 drives NS1 with the value of EW1. turn2 and turn2_dir do the same for NS2 and EW2. A conflicted target line is not driven.
- R9: A bus counts one use for each of: a read (rd_mode = 1 and rd_bus selects it), a write (its wr_en bit and drv_en), and a turn of its pair. A bus with more than one use is in conflict. `cfg_err` is high while any bus is in conflict, and a conflicted bus has bus_oe = 0.
- R10: When bus_oe[i] is 0, bus_out[i] is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| col_clk | input | 1 | Column clock |
| col_rst | input | 1 | Column reset, synchronous, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 22 | Configuration word |
| a_in | input | 4 | A inputs from N, S, E, W neighbours |
| b_in | input | 4 | B inputs from N, S, E, W neighbours |
| bus_in | input | 4 | Resolved levels of NS1, EW1, NS2, EW2 |
| a_out | output | 1 | A output to all neighbours |
| b_out | output | 1 | B output to all neighbours |
| bus_out | output | 4 | Drive data for each bus line |
| bus_oe | output | 4 | Drive enable for each bus line |
| cfg_err | output | 1 | Bus used by more than one operation |

## Verification
The hardest case to reach from the ports is the registered function in state 3 with read mode 2. The flip-flop then feeds its own next value, so what the cell outputs depends on every earlier clock edge. The stimulus sets both selectors to constant 1, which makes the flip-flop toggle, and then drives the A selector from a neighbour pin so the feedback is gated by that pin. A bench-side copy of the flip-flop, computed from the requirements, follows it edge by edge. The bus conditions are covered by sweeping every combination of write enables, driver modes, turns and read targets, so that each way two operations can meet on one line is produced at least once.

// File: rtl/sac_pkg.sv
package sac_pkg;
  localparam int NBR   = 4;   // neighbour directions
  localparam int NBUS  = 4;   // local bus lines
  localparam int SEL_W = 3;   // input selector width
  localparam int ST_W  = 2;   // function state width
  localparam int RB_W  = $clog2(NBUS);

  typedef struct packed {
    logic            turn2_dir;
    logic            turn2;
    logic            turn1_dir;
    logic            turn1;
    logic            drv_tri;
    logic            drv_en;
    logic [NBUS-1:0] wr_en;
    logic [RB_W-1:0] rd_bus;
    logic [1:0]      rd_mode;
    logic [ST_W-1:0] state;
    logic [SEL_W-1:0] b_sel;
    logic [SEL_W-1:0] a_sel;
  } cell_cfg_t;

  localparam int CFG_W = $bits(cell_cfg_t);

  // neighbour pick, or constant one for the upper codes
  function automatic logic pick_input(logic [NBR-1:0] v, logic [SEL_W-1:0] s);
    if (s[SEL_W-1]) return 1'b1;
    return v[s[SEL_W-2:0]];
  endfunction

  // returns {a, b} for a function state
  function automatic logic [1:0] cell_fn(logic [ST_W-1:0] st, logic l, logic r, logic q);
    case (st)
      2'd0:    return {l, r};
      2'd1:    return {r, l};
      2'd2:    return {l ^ r, l & r};
      default: return {q, q};
    endcase
  endfunction
endpackage

// File: rtl/sac_input_mux.sv
module sac_input_mux
  import sac_pkg::*;
(
  input  logic [NBR-1:0]   nbr,
  input  logic [SEL_W-1:0] sel,
  output logic             y
);
  always_comb y = pick_input(nbr, sel);
endmodule

// File: rtl/sac_func_core.sv
module sac_func_core
  import sac_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [ST_W-1:0] state,
  input  logic [1:0]      rd_mode,
  input  logic [RB_W-1:0] rd_bus,
  input  logic [NBUS-1:0] bus_in,
  input  logic            a_pick,
  input  logic            b_pick,
  output logic            a_out,
  output logic            b_out
);
  logic rd_val;
  logic left_t;
  logic right_t;
  logic q;

  always_comb begin
    case (rd_mode)
      2'd1:    rd_val = bus_in[rd_bus];
      2'd2:    rd_val = q;
      default: rd_val = 1'b1;
    endcase
  end

  assign left_t  = a_pick & rd_val;
  assign right_t = b_pick;

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= left_t ^ right_t;
  end

  always_comb {a_out, b_out} = cell_fn(state, left_t, right_t, q);

  // R4: state 1 exchanges the two product terms
  a_r4_swap: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd1) |-> (a_out == right_t) && (b_out == left_t));

  // R5: XOR and AND of the same pair are never both high
  a_r5_xor_and_exclusive: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd2) |-> !(a_out && b_out));

  // R6: registered state drives both outputs alike
  a_r6_reg_both: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd3) |-> (a_out == b_out));
endmodule

// File: rtl/sac_bus_ctrl.sv
module sac_bus_ctrl
  import sac_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NBUS-1:0] wr_en,
  input  logic            drv_en,
  input  logic            drv_tri,
  input  logic            turn1,
  input  logic            turn1_dir,
  input  logic            turn2,
  input  logic            turn2_dir,
  input  logic [1:0]      rd_mode,
  input  logic [RB_W-1:0] rd_bus,
  input  logic [NBUS-1:0] bus_in,
  input  logic            wdata,
  input  logic            b_pick,
  output logic [NBUS-1:0] bus_out,
  output logic [NBUS-1:0] bus_oe,
  output logic            cfg_err
);
  localparam int NPAIR = NBUS / 2;

  logic [NPAIR-1:0] turn_on;
  logic [NPAIR-1:0] turn_dir;
  logic [NBUS-1:0]  conflict;
  logic [NBUS-1:0]  turn_tgt;
  logic [NBUS-1:0]  wr_ok;

  assign turn_on  = {turn2, turn1};
  assign turn_dir = {turn2_dir, turn1_dir};

  for (genvar i = 0; i < NBUS; i++) begin : g_bus
    localparam int P     = i / 2;
    localparam bit IS_NS = (i % 2) == 0;
    logic       use_rd;
    logic       use_wr;
    logic       use_tn;
    logic [1:0] uses;

    assign use_rd = (rd_mode == 2'd1) && (rd_bus == RB_W'(i));
    assign use_wr = wr_en[i] & drv_en;
    assign use_tn = turn_on[P];
    assign uses   = 2'(use_rd) + 2'(use_wr) + 2'(use_tn);
    assign conflict[i] = uses > 2'd1;

    // a north-south line is the target when the direction bit is set
    assign turn_tgt[i] = turn_on[P] & (IS_NS ? turn_dir[P] : ~turn_dir[P]);
    assign wr_ok[i]    = use_wr & (~drv_tri | b_pick);

    assign bus_oe[i]  = ~conflict[i] & (wr_ok[i] | turn_tgt[i]);
    assign bus_out[i] = bus_oe[i] & (turn_tgt[i] ? bus_in[i ^ 1] : wdata);

    // R9: a line in conflict is left undriven
    a_r9_conflict_quiet: assert property (@(posedge clk) disable iff (rst)
      conflict[i] |-> !bus_oe[i]);

    // R10: released line carries zero data
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
      !bus_oe[i] |-> !bus_out[i]);

    // R7: dynamic tri-state releases a write-only line when B is low
    a_r7_tri_release: assert property (@(posedge clk) disable iff (rst)
      (drv_tri && !b_pick && !turn_tgt[i]) |-> !bus_oe[i]);
  end

  assign cfg_err = |conflict;
endmodule

// File: rtl/sac_cell.sv
module sac_cell
  import sac_pkg::*;
(
  input  logic             col_clk,
  input  logic             col_rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic [NBR-1:0]   a_in,
  input  logic [NBR-1:0]   b_in,
  input  logic [NBUS-1:0]  bus_in,
  output logic             a_out,
  output logic             b_out,
  output logic [NBUS-1:0]  bus_out,
  output logic [NBUS-1:0]  bus_oe,
  output logic             cfg_err
);
  cell_cfg_t cfg;
  logic [1:0] picks;

  always_ff @(posedge col_clk) begin
    if (col_rst)     cfg <= '0;
    else if (cfg_we) cfg <= cell_cfg_t'(cfg_wdata);
  end

  // R1: configuration word is taken on the strobe
  a_r1_cfg_load: assert property (@(posedge col_clk) disable iff (col_rst)
    cfg_we |=> (cfg == cell_cfg_t'($past(cfg_wdata))));

  // R2: two independent selectors, index 0 for A and 1 for B
  for (genvar s = 0; s < 2; s++) begin : g_sel
    sac_input_mux i_mux (
      .nbr (s == 0 ? a_in : b_in),
      .sel (s == 0 ? cfg.a_sel : cfg.b_sel),
      .y   (picks[s])
    );
  end

  sac_func_core i_core (
    .clk     (col_clk),
    .rst     (col_rst),
    .state   (cfg.state),
    .rd_mode (cfg.rd_mode),
    .rd_bus  (cfg.rd_bus),
    .bus_in  (bus_in),
    .a_pick  (picks[0]),
    .b_pick  (picks[1]),
    .a_out   (a_out),
    .b_out   (b_out)
  );

  sac_bus_ctrl i_bus (
    .clk       (col_clk),
    .rst       (col_rst),
    .wr_en     (cfg.wr_en),
    .drv_en    (cfg.drv_en),
    .drv_tri   (cfg.drv_tri),
    .turn1     (cfg.turn1),
    .turn1_dir (cfg.turn1_dir),
    .turn2     (cfg.turn2),
    .turn2_dir (cfg.turn2_dir),
    .rd_mode   (cfg.rd_mode),
    .rd_bus    (cfg.rd_bus),
    .bus_in    (bus_in),
    .wdata     (a_out),
    .b_pick    (picks[1]),
    .bus_out   (bus_out),
    .bus_oe    (bus_oe),
    .cfg_err   (cfg_err)
  );
endmodule

// File: tb/test_sac_cell.sv
module test_sac_cell;
  logic        col_clk = 1'b0;
  logic        col_rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [21:0] cfg_wdata = '0;
  logic [3:0]  a_in = '0, b_in = '0, bus_in = '0;
  logic        a_out, b_out, cfg_err;
  logic [3:0]  bus_out, bus_oe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [21:0] cfg_exp = '0;
  logic        q_exp = 1'b0;

  sac_cell i_sac_cell (
    .col_clk(col_clk), .col_rst(col_rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .a_in(a_in), .b_in(b_in), .bus_in(bus_in), .a_out(a_out), .b_out(b_out),
    .bus_out(bus_out), .bus_oe(bus_oe), .cfg_err(cfg_err)
  );

  always #4 col_clk = ~col_clk;   // 125 MHz

  // selector value from a 3-bit code
  function automatic logic m_sel(logic [3:0] v, logic [2:0] c);
    return (c >= 3'd4) ? 1'b1 : v[c[1:0]];
  endfunction

  // product terms {left, right}
  function automatic logic [1:0] m_terms(logic [21:0] w, logic [3:0] av, logic [3:0] bv,
                                         logic [3:0] bus, logic q);
    logic rd;
    rd = 1'b1;
    if (w[9:8] == 2'd1) rd = bus[w[11:10]];
    if (w[9:8] == 2'd2) rd = q;
    return {m_sel(av, w[2:0]) & rd, m_sel(bv, w[5:3])};
  endfunction

  function automatic logic [1:0] m_out(logic [21:0] w, logic [3:0] av, logic [3:0] bv,
                                       logic [3:0] bus, logic q);
    logic [1:0] t;
    t = m_terms(w, av, bv, bus, q);
    case (w[7:6])
      2'd0: return t;
      2'd1: return {t[0], t[1]};
      2'd2: return {t[1] ^ t[0], t[1] & t[0]};
      default: return {q, q};
    endcase
  endfunction

  // {err, oe[3:0], out[3:0]}
  function automatic logic [8:0] m_bus(logic [21:0] w, logic [3:0] av, logic [3:0] bv,
                                       logic [3:0] bus, logic q);
    logic [3:0] oe, dout;
    logic       err, aval;
    aval = m_out(w, av, bv, bus, q) >> 1;
    err = 1'b0; oe = '0; dout = '0;
    for (int k = 0; k < 4; k++) begin
      int n;
      logic tn, tgt, wr;
      tn = (k < 2) ? w[18] : w[20];
      n = 0;
      if (w[9:8] == 2'd1 && w[11:10] == 2'(k)) n++;
      if (w[12+k] && w[16]) n++;
      if (tn) n++;
      // pair direction: 0 means EW (odd index) is target
      tgt = tn && (((k < 2) ? w[19] : w[21]) == ((k % 2) == 0));
      wr  = w[12+k] && w[16] && (!w[17] || m_sel(bv, w[5:3]));
      if (n > 1) err = 1'b1;
      else if (tgt) begin oe[k] = 1'b1; dout[k] = bus[k ^ 1]; end
      else if (wr)  begin oe[k] = 1'b1; dout[k] = aval; end
    end
    return {err, oe, dout};
  endfunction

  // bench copies of the configuration register and the flip-flop
  always @(posedge col_clk) begin
    logic [1:0] t;
    cycles <= cycles + 1;
    t = m_terms(cfg_exp, a_in, b_in, bus_in, q_exp);
    if (col_rst) begin cfg_exp <= '0; q_exp <= 1'b0; end
    else begin
      q_exp <= t[1] ^ t[0];
      if (cfg_we) cfg_exp <= cfg_wdata;
    end
  end

  task automatic chk(string tag, logic [8:0] got, logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h cfg=%h a=%h b=%h bus=%h",
               tag, got, exp, cfg_exp, a_in, b_in, bus_in);
    end
  endtask

  task automatic load(logic [21:0] w);
    @(negedge col_clk);
    cfg_we = 1'b1; cfg_wdata = w;
    @(negedge col_clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    #1000000000;
    errors++;
    $display("FAIL watchdog expired after %0d cycles", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge col_clk);
    col_rst = 1'b0;
    // R1: reset leaves the all-zero configuration
    a_in = 4'b0001; b_in = 4'b1110; bus_in = 4'b1111;
    #1 chk("R1", {a_out, b_out}, 9'b10);
    chk("R1", {cfg_err, bus_oe, bus_out}, 9'd0);

    // combinational sweep: selectors, read path, states 0..2
    for (int as = 0; as < 8; as++)
      for (int bs = 0; bs < 8; bs++)
        for (int st = 0; st < 3; st++)
          for (int rm = 0; rm < 2; rm++) begin
            logic [21:0] w;
            string tag;
            w = '0;
            w[2:0] = 3'(as); w[5:3] = 3'(bs); w[7:6] = 2'(st);
            w[9:8] = 2'(rm); w[11:10] = 2'(as);
            tag = (rm == 1) ? "R3" : (st == 2) ? "R5" : (st == 1) ? "R4" : "R2";
            load(w);
            for (int v = 0; v < 256; v++) begin
              a_in = v[3:0]; b_in = v[7:4]; bus_in = v[3:0] ^ {v[5:4], v[7:6]};
              #1;
              chk(tag, {7'd0, a_out, b_out}, {7'd0, m_out(cfg_exp, a_in, b_in, bus_in, q_exp)});
            end
          end

    // bus sweep: writes, tri-state, turns, reads and their conflicts
    for (int c = 0; c < 8192; c++) begin
      logic [21:0] w;
      string tag;
      w = '0;
      w[2:0] = 3'd4;
      w[9:8] = {1'b0, c[0]}; w[11:10] = c[2:1]; w[15:12] = c[6:3];
      w[16] = c[7]; w[17] = c[8]; w[18] = c[9]; w[19] = c[10];
      w[20] = c[11]; w[21] = c[12];
      load(w);
      for (int v = 0; v < 4; v++) begin
        logic [8:0] e;
        a_in = 4'd0; b_in = {3'd0, v[0]}; bus_in = v[1] ? 4'b1010 : 4'b0101;
        #1;
        e = m_bus(cfg_exp, a_in, b_in, bus_in, q_exp);
        tag = e[8] ? "R9" : (w[18] || w[20]) ? "R8" : "R7";
        chk(tag, {cfg_err, bus_oe, bus_out}, e);
        chk("R10", {5'd0, bus_out & ~bus_oe}, 9'd0);
      end
    end

    // R6: flip-flop fed back through the read path toggles every edge
    load({12'd0, 2'd2, 2'd3, 3'd4, 3'd4});
    a_in = 4'd0; b_in = 4'd0;
    for (int k = 0; k < 24; k++) begin
      logic prev;
      prev = a_out;
      @(negedge col_clk); #1;
      chk("R6", {7'd0, a_out, b_out}, {7'd0, q_exp, q_exp});
      chk("R6", {8'd0, a_out}, {8'd0, ~prev});
    end
    // R6: same loop, now gated by the north A pin
    load({12'd0, 2'd2, 2'd3, 3'd4, 3'd0});
    for (int k = 0; k < 32; k++) begin
      @(negedge col_clk);
      a_in = {3'd0, k[1] ^ k[3]}; b_in = {3'd0, k[2]};
      #1 chk("R6", {7'd0, a_out, b_out}, {7'd0, q_exp, q_exp});
    end

    // R1: reset clears register and flip-flop
    @(negedge col_clk); col_rst = 1'b1;
    @(negedge col_clk); col_rst = 1'b0;
    a_in = 4'b0000; b_in = 4'b0001; #1;
    chk("R1", {7'd0, a_out, b_out}, 9'b01);
    chk("R1", {cfg_err, bus_oe, bus_out}, 9'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule